// File: doc/BRIEF.md
# Toggle-based event pulse synchronizer

This block moves single-cycle event strobes from one clock domain into a second domain that runs without any fixed phase or frequency relationship to the first. An accepted strobe on the source side inverts a registered toggle level. That level is the only signal that crosses into the destination domain. The destination passes the level through a chain of flip-flops on its own clock. Each change of the synchronized level, whether it rises or falls, becomes one output strobe exactly one destination cycle wide. Because the event is held as a level and not as a short pulse, a strobe much narrower than a destination clock period is still delivered.

To keep events apart, the destination sends its captured level back to the source through a return chain. A busy flag on the source side stays high from the cycle after an accepted strobe until that level has come back. A strobe that arrives while busy is high is dropped. The caller uses busy to pace its events, and this round trip sets the minimum spacing between events.

Top module: `toggle_pulse_sync`

## Requirements
- R1: While either reset is asserted (active low) and right after release, `dst_pulse` and `src_busy` are 0.
- R2: A `src_pulse` that is high for one source cycle while `src_busy` is 0 yields exactly one `dst_pulse`, even when the destination period is longer than the source period.
- R3: Every `dst_pulse` is high for exactly one destination cycle.
- R4: Both directions of the toggle level produce an event: two spaced accepted strobes yield two output strobes.
- R5: `src_busy` is 1 in the source cycle after an accepted strobe, and any `src_pulse` sampled while `src_busy` is 1 is dropped and produces no output strobe.
- R6: The synchronizer depth `STAGES` is a parameter with a minimum of 2. The output strobe appears within `STAGES`+3 destination cycles of the accepting source edge.
- R7: `src_busy` returns to 0 after the event has been delivered and its level has come back through the return chain, within 40 source cycles for the bench configuration.
- R8: With `src_pulse` held high, an event is accepted on every source edge at which `src_busy` is 0, and the number of output strobes equals the number of accepted events.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| src_clk | input | 1 | Source domain clock |
| src_rst_n | input | 1 | Source domain asynchronous reset, active low |
| src_pulse | input | 1 | Event strobe in the source domain |
| src_busy | output | 1 | High while an event is still in flight; strobes are dropped while high |
| dst_clk | input | 1 | Destination domain clock |
| dst_rst_n | input | 1 | Destination domain asynchronous reset, active low |
| dst_pulse | output | 1 | One-cycle event strobe in the destination domain |

## Verification
The bench builds the block with `STAGES` = 3. The source clock runs at 10 ns and the destination clock at 27 ns, so every input strobe is far narrower than a destination period, which is the case where level conversion matters. A depth above the minimum makes the latency bound and the longer busy round trip observable. Holding the strobe high exercises acceptance at exactly the edges where busy has just cleared.

// File: rtl/toggle_pulse_sync.sv
module toggle_pulse_sync #(
  parameter int STAGES = 2
) (
  input  logic src_clk,
  input  logic src_rst_n,
  input  logic src_pulse,
  output logic src_busy,
  input  logic dst_clk,
  input  logic dst_rst_n,
  output logic dst_pulse
);

  logic              tog;
  logic              accept;
  logic [STAGES-1:0] back;
  logic [STAGES-1:0] fwd;
  logic              seen;

  initial p_min_depth_r6: assert (STAGES >= 2) else $error("STAGES below 2");

  assign accept   = src_pulse & ~src_busy;
  assign src_busy = tog ^ back[STAGES-1];

  always_ff @(posedge src_clk or negedge src_rst_n) begin
    if (!src_rst_n) begin
      tog  <= 1'b0;
      back <= '0;
    end else begin
      tog  <= tog ^ accept;
      back <= {back[STAGES-2:0], seen};
    end
  end

  always_ff @(posedge dst_clk or negedge dst_rst_n) begin
    if (!dst_rst_n) begin
      fwd  <= '0;
      seen <= 1'b0;
    end else begin
      fwd  <= {fwd[STAGES-2:0], tog};
      seen <= fwd[STAGES-1];
    end
  end

  assign dst_pulse = fwd[STAGES-1] ^ seen;

  p_busy_after_accept_r5: assert property (@(posedge src_clk) disable iff (!src_rst_n)
    (src_pulse && !src_busy) |=> src_busy);

  p_drop_while_busy_r5: assert property (@(posedge src_clk) disable iff (!src_rst_n)
    src_busy |=> $stable(tog));

  p_one_cycle_r3: assert property (@(posedge dst_clk) disable iff (!dst_rst_n)
    dst_pulse |=> !dst_pulse);

  p_level_holds_r4: assert property (@(posedge dst_clk) disable iff (!dst_rst_n)
    dst_pulse |=> $stable(fwd[STAGES-1]));

endmodule

// File: tb/test_toggle_pulse_sync.sv
module test_toggle_pulse_sync;
  localparam int STAGES = 3;

  logic src_clk = 1'b0;
  logic dst_clk = 1'b0;
  logic src_rst_n = 1'b0;
  logic dst_rst_n = 1'b0;
  logic src_pulse = 1'b0;
  logic src_busy;
  logic dst_pulse;

  int checks = 0;
  int failures = 0;
  int seen_cnt = 0;
  int exp_cnt = 0;
  bit wide_seen = 1'b0;
  bit last_hi = 1'b0;
  bit done = 1'b0;

  always #5 src_clk = ~src_clk;
  always #13.5 dst_clk = ~dst_clk;

  toggle_pulse_sync #(.STAGES(STAGES)) i_toggle_pulse_sync (
    .src_clk(src_clk), .src_rst_n(src_rst_n), .src_pulse(src_pulse), .src_busy(src_busy),
    .dst_clk(dst_clk), .dst_rst_n(dst_rst_n), .dst_pulse(dst_pulse)
  );

  always @(negedge dst_clk) begin
    if (dst_pulse) seen_cnt++;
    if (dst_pulse && last_hi) wide_seen = 1'b1;
    last_hi = dst_pulse;
  end

  task automatic check(input string req, input int act, input int expv);
    checks++;
    if (act != expv) begin
      failures++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, expv);
    end
  endtask

  task automatic strobe();
    @(negedge src_clk);
    if (!src_busy) exp_cnt++;
    src_pulse = 1'b1;
    @(negedge src_clk);
    src_pulse = 1'b0;
  endtask

  task automatic wait_delivery(input string req);
    repeat (STAGES + 3) @(negedge dst_clk);
    check(req, seen_cnt, exp_cnt);
  endtask

  task automatic wait_idle(input string req);
    int n = 0;
    while (src_busy && n < 40) begin
      @(negedge src_clk);
      n++;
    end
    check(req, int'(src_busy), 0);
  endtask

  task automatic t_reset();
    check("R1 dst_pulse in reset", int'(dst_pulse), 0);
    check("R1 src_busy in reset", int'(src_busy), 0);
    #20;
    src_rst_n = 1'b1;
    dst_rst_n = 1'b1;
    repeat (3) @(negedge dst_clk);
    check("R1 dst_pulse after release", int'(dst_pulse), 0);
    check("R1 src_busy after release", int'(src_busy), 0);
  endtask

  task automatic t_single();
    strobe();
    check("R5 busy after accept", int'(src_busy), 1);
    wait_delivery("R2 single narrow strobe / R6 latency");
    wait_idle("R7 busy clears");
  endtask

  task automatic t_both_edges();
    strobe();
    wait_delivery("R4 first toggle");
    wait_idle("R7 busy clears first");
    strobe();
    wait_delivery("R4 second toggle");
    wait_idle("R7 busy clears second");
  endtask

  task automatic t_drop();
    strobe();
    check("R5 busy before second strobe", int'(src_busy), 1);
    strobe();
    strobe();
    wait_delivery("R5 strobes while busy dropped");
    wait_idle("R7 busy clears after drop");
    repeat (STAGES + 3) @(negedge dst_clk);
    check("R5 no late extra strobe", seen_cnt, exp_cnt);
  endtask

  task automatic t_held();
    int start = exp_cnt;
    @(negedge src_clk);
    src_pulse = 1'b1;
    for (int i = 0; i < 80; i++) begin
      if (!src_busy) exp_cnt++;
      @(negedge src_clk);
    end
    src_pulse = 1'b0;
    check("R8 several accepted while held", int'(exp_cnt - start > 2), 1);
    wait_delivery("R8 held input count");
    wait_idle("R7 busy clears after held");
  endtask

  initial begin
    #2ms;
    if (!done) begin
      failures++;
      checks++;
      $display("FAIL watchdog expired");
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end

  initial begin
    t_reset();
    t_single();
    t_both_edges();
    t_drop();
    t_held();
    check("R3 one-cycle output width", int'(wide_seen), 0);
    done = 1'b1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end
endmodule